// File: doc/BRIEF.md
# Multiplexed 16-Bit Memory Bus Controller

This block turns single processor-side memory requests into cycles on an external bus where sixteen shared pins carry both addresses and data. Each request holds a 32-bit byte address, a read/write flag, a four-bit byte mask and 32 bits of write data. It is accepted with a valid signal and finished with a one-cycle ready pulse. The external memory is organised as 16-bit words with a 31-bit word address. Every word transaction therefore sends the address in two halves, each captured by external transparent latches under its own strobe, before a single data phase.

A request whose mask enables all four bytes becomes two word transactions: the even word first, then the odd word. Any other mask touches only one 16-bit half and needs one transaction. A byte store places the chosen byte on both halves of the pins and pulls only the matching byte strobe low. Addresses in the top 256 bytes of the address space never reach the external bus. They are handed to a separate register port, and the external read and write strobes stay inactive. A two-bit input sets how the write strobes are shaped against the clock, to suit different memory parts.

Top module: `adbus_ctrl`

## Requirements
- R1: For each external word transaction, the first cycle after the request is accepted (or after the previous data phase) drives `le_lo` high with `ad_out` equal to word address bits 15:0, and the next cycle drives `le_hi` high with `ad_out` equal to {0, word address bits 30:16}. The word address is byte address bits 31:1 and `bus_dir` is low in both cycles.
- R2: A read's data phase is the cycle right after the `le_hi` cycle. In it `oe_n` is low, `bus_dir` is high and both write strobes are high. The block captures `ad_in` at the end of that cycle.
- R3: A write's data phase is the cycle right after the `le_hi` cycle. In it `oe_n` is high and `bus_dir` is low. `we_lo_n` (pins 7:0) is low when the selected half's lower mask bit is set, and `we_hi_n` (pins 15:8) is low when its upper mask bit is set.
- R4: Mask 1111 gives two transactions, at word addresses {addr[31:2],0} and then {addr[31:2],1}. They carry write data 15:0 and then 31:16. A read returns the first word in bits 15:0 and the second word in bits 31:16.
- R5: Any other mask gives one transaction on the upper half (word {addr[31:2],1}, mask bits 3:2, data 31:16) when mask[1:0] is 00, and on the lower half (word {addr[31:2],0}, mask bits 1:0, data 15:0) otherwise. The read data lands in that half and the other half reads zero.
- R6: When only one byte of the selected half is enabled, that byte appears on both `ad_out[15:8]` and `ad_out[7:0]` during the data phase. When both bytes are enabled, the half's data appears unchanged.
- R7: A request with address bits 31:8 all ones raises `prf_sel` for exactly one cycle, the cycle after acceptance. During that cycle `prf_we`, `prf_addr` (address bits 7:0) and `prf_wdata` are valid. `le_hi` stays low, `oe_n` and both write strobes stay high, and a read returns the `prf_rdata` value present in that cycle.
- R8: With `we_mode` 0 or 3 an active write strobe is low for the whole data-phase cycle. With mode 1 it is low only while `clk` is low, and with mode 2 only while `clk` is high.
- R9: `rsp_ready` is high for exactly one cycle, the cycle after the last data phase (or after the `prf_sel` cycle). `rsp_rdata` holds the read result during that cycle.
- R10: While in reset and when idle, both latch strobes are low, `oe_n` and both write strobes are high, `bus_dir` is high and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `rsp_ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_mask | input | 4 | Byte enables of the 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| we_mode | input | 2 | Write strobe shaping select |
| ad_out | output | 16 | Value driven onto the shared pins |
| ad_in | input | 16 | Value read from the shared pins |
| bus_dir | output | 1 | 0 = block drives pins, 1 = pins are input |
| le_lo | output | 1 | Latch strobe, low address half |
| le_hi | output | 1 | Latch strobe, high address half |
| oe_n | output | 1 | Active-low memory output enable |
| we_lo_n | output | 1 | Active-low write strobe, bits 7:0 |
| we_hi_n | output | 1 | Active-low write strobe, bits 15:8 |
| prf_sel | output | 1 | Register port select pulse |
| prf_we | output | 1 | Register port write flag |
| prf_addr | output | 8 | Register port offset |
| prf_wdata | output | 32 | Register port write data |
| prf_rdata | input | 32 | Register port read data |

## Verification
A wrong sequencer state shows up within one cycle as a latch strobe or data phase out of place. For example, `oe_n` falling without an `le_hi` in the cycle before, or `le_hi` without `le_lo` before it. A bad half select or word increment shows up as a wrong value on `ad_out` during an address phase, or as read data in the wrong half at the ready pulse. Strobe shaping errors are caught by sampling each write strobe once in each clock phase of the data cycle. Peripheral routing faults appear as an external strobe or `le_hi` during the `prf_sel` cycle.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALO,
    ST_AHI,
    ST_DATA,
    ST_PERI,
    ST_DONE
  } adbus_st_t;
endpackage

// File: rtl/adbus_decode.sv
module adbus_decode #(
  parameter int AW = 32,
  parameter int PW = 8
) (
  input  logic [AW-1:2] addr_hi,
  input  logic [3:0]    mask,
  output logic          is_peri,
  output logic          two_tx,
  output logic          start_half,
  output logic [AW-2:0] start_waddr
);
  always_comb begin
    is_peri     = &addr_hi[AW-1:PW];
    two_tx      = &mask;
    start_half  = two_tx ? 1'b0 : (mask[1:0] == 2'b00);
    start_waddr = {addr_hi, start_half};
  end
endmodule

// File: rtl/adbus_lane.sv
module adbus_lane #(
  parameter int BW = 16
) (
  input  logic [2*BW-1:0] wdata,
  input  logic [3:0]      mask,
  input  logic            half,
  output logic [BW-1:0]   lane_data,
  output logic [1:0]      lane_we
);
  localparam int HB = BW / 2;
  logic [BW-1:0] hw;

  always_comb begin
    hw      = half ? wdata[2*BW-1:BW] : wdata[BW-1:0];
    lane_we = half ? mask[3:2] : mask[1:0];
    case (lane_we)
      2'b01:   lane_data = {hw[HB-1:0], hw[HB-1:0]};
      2'b10:   lane_data = {hw[BW-1:HB], hw[BW-1:HB]};
      default: lane_data = hw;
    endcase
  end
endmodule

// File: rtl/adbus_wshape.sv
module adbus_wshape #(
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic [1:0]    mode,
  input  logic [NL-1:0] wen,
  output logic [NL-1:0] we_n
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    always_comb begin
      case (mode)
        2'd1:    we_n[i] = ~(wen[i] & ~clk);
        2'd2:    we_n[i] = ~(wen[i] & clk);
        default: we_n[i] = ~wen[i];
      endcase
    end
  end
endmodule

// File: rtl/adbus_ctrl.sv
module adbus_ctrl #(
  parameter int AW = 32,
  parameter int BW = 16,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [3:0]      req_mask,
  input  logic [2*BW-1:0] req_wdata,
  output logic            rsp_ready,
  output logic [2*BW-1:0] rsp_rdata,
  input  logic [1:0]      we_mode,
  output logic [BW-1:0]   ad_out,
  input  logic [BW-1:0]   ad_in,
  output logic            bus_dir,
  output logic            le_lo,
  output logic            le_hi,
  output logic            oe_n,
  output logic            we_lo_n,
  output logic            we_hi_n,
  output logic            prf_sel,
  output logic            prf_we,
  output logic [PW-1:0]   prf_addr,
  output logic [2*BW-1:0] prf_wdata,
  input  logic [2*BW-1:0] prf_rdata
);
  import adbus_pkg::*;

  localparam int DW   = 2 * BW;
  localparam int WAW  = AW - 1;
  localparam int HI_W = WAW - BW;
  localparam int PAD  = BW - HI_W;

  adbus_st_t      st;
  logic           we_q, half_q, second_q;
  logic [3:0]     mask_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [PW-1:0]  paddr_q;
  logic [WAW-1:0] waddr_q;
  logic [BW-1:0]  ad_q;
  logic           dir_q, lel_q, leh_q, oen_q, rdy_q, psel_q;
  logic [1:0]     wen_q, we_n;

  logic           d_peri, d_two, d_half;
  logic [WAW-1:0] d_waddr, nxt_waddr;
  logic [BW-1:0]  lane_data;
  logic [1:0]     lane_we;

  adbus_decode #(.AW(AW), .PW(PW)) u_dec (
    .addr_hi    (req_addr[AW-1:2]),
    .mask       (req_mask),
    .is_peri    (d_peri),
    .two_tx     (d_two),
    .start_half (d_half),
    .start_waddr(d_waddr)
  );

  adbus_lane #(.BW(BW)) u_lane (
    .wdata    (wdata_q),
    .mask     (mask_q),
    .half     (half_q),
    .lane_data(lane_data),
    .lane_we  (lane_we)
  );

  adbus_wshape #(.NL(2)) u_wsh (
    .clk (clk),
    .mode(we_mode),
    .wen (wen_q),
    .we_n(we_n)
  );

  assign nxt_waddr = waddr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      we_q     <= 1'b0;
      half_q   <= 1'b0;
      second_q <= 1'b0;
      mask_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      paddr_q  <= '0;
      waddr_q  <= '0;
      ad_q     <= '0;
      dir_q    <= 1'b1;
      lel_q    <= 1'b0;
      leh_q    <= 1'b0;
      oen_q    <= 1'b1;
      wen_q    <= 2'b00;
      rdy_q    <= 1'b0;
      psel_q   <= 1'b0;
    end else begin
      dir_q  <= 1'b1;
      lel_q  <= 1'b0;
      leh_q  <= 1'b0;
      oen_q  <= 1'b1;
      wen_q  <= 2'b00;
      rdy_q  <= 1'b0;
      psel_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          we_q     <= req_we;
          mask_q   <= req_mask;
          wdata_q  <= req_wdata;
          paddr_q  <= req_addr[PW-1:0];
          rdata_q  <= '0;
          waddr_q  <= d_waddr;
          half_q   <= d_half;
          second_q <= d_two;
          if (d_peri) begin
            st     <= ST_PERI;
            psel_q <= 1'b1;
          end else begin
            st    <= ST_ALO;
            ad_q  <= d_waddr[BW-1:0];
            lel_q <= 1'b1;
            dir_q <= 1'b0;
          end
        end
        ST_ALO: begin
          st    <= ST_AHI;
          ad_q  <= {{PAD{1'b0}}, waddr_q[WAW-1:BW]};
          leh_q <= 1'b1;
          dir_q <= 1'b0;
        end
        ST_AHI: begin
          st <= ST_DATA;
          if (we_q) begin
            ad_q  <= lane_data;
            wen_q <= lane_we;
            dir_q <= 1'b0;
          end else begin
            oen_q <= 1'b0;
          end
        end
        ST_DATA: begin
          if (!we_q) begin
            if (half_q) rdata_q[DW-1:BW] <= ad_in;
            else        rdata_q[BW-1:0]  <= ad_in;
          end
          if (second_q) begin
            second_q <= 1'b0;
            half_q   <= 1'b1;
            waddr_q  <= nxt_waddr;
            ad_q     <= nxt_waddr[BW-1:0];
            lel_q    <= 1'b1;
            dir_q    <= 1'b0;
            st       <= ST_ALO;
          end else begin
            rdy_q <= 1'b1;
            st    <= ST_DONE;
          end
        end
        ST_PERI: begin
          if (!we_q) rdata_q <= prf_rdata;
          rdy_q <= 1'b1;
          st    <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rsp_ready = rdy_q;
  assign rsp_rdata = rdata_q;
  assign ad_out    = ad_q;
  assign bus_dir   = dir_q;
  assign le_lo     = lel_q;
  assign le_hi     = leh_q;
  assign oe_n      = oen_q;
  assign we_lo_n   = we_n[0];
  assign we_hi_n   = we_n[1];
  assign prf_sel   = psel_q;
  assign prf_we    = we_q;
  assign prf_addr  = paddr_q;
  assign prf_wdata = wdata_q;
endmodule

// File: rtl/adbus_ctrl_chk.sv
module adbus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic le_lo,
  input logic le_hi,
  input logic bus_dir,
  input logic oe_n,
  input logic we_lo_n,
  input logic we_hi_n,
  input logic prf_sel,
  input logic rsp_ready
);
  a_r1_lehi_follows_lelo: assert property (@(posedge clk) disable iff (rst)
    le_hi |-> $past(le_lo));

  a_r1_one_latch_at_a_time: assert property (@(posedge clk) disable iff (rst)
    !(le_lo && le_hi));

  a_r2_read_after_lehi: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> ($past(le_hi) && bus_dir && we_lo_n && we_hi_n));

  a_r3_write_drives_bus: assert property (@(posedge clk) disable iff (rst)
    (!we_lo_n || !we_hi_n) |-> (!bus_dir && oe_n));

  a_r7_peri_no_ext_strobes: assert property (@(posedge clk) disable iff (rst)
    prf_sel |-> (oe_n && we_lo_n && we_hi_n && !le_hi));

  a_r7_peri_then_ready: assert property (@(posedge clk) disable iff (rst)
    prf_sel |=> rsp_ready);

  a_r9_ready_single: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);
endmodule

bind adbus_ctrl adbus_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .le_lo    (le_lo),
  .le_hi    (le_hi),
  .bus_dir  (bus_dir),
  .oe_n     (oe_n),
  .we_lo_n  (we_lo_n),
  .we_hi_n  (we_hi_n),
  .prf_sel  (prf_sel),
  .rsp_ready(rsp_ready)
);

// File: tb/sim_adbus_ctrl.sv
module sim_adbus_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic [1:0]  we_mode = 2'd0;
  logic [15:0] ad_out, ad_in = '0;
  logic        bus_dir, le_lo, le_hi, oe_n, we_lo_n, we_hi_n;
  logic        prf_sel, prf_we;
  logic [7:0]  prf_addr;
  logic [31:0] prf_wdata, prf_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  adbus_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .we_mode(we_mode),
    .ad_out(ad_out), .ad_in(ad_in), .bus_dir(bus_dir), .le_lo(le_lo),
    .le_hi(le_hi), .oe_n(oe_n), .we_lo_n(we_lo_n), .we_hi_n(we_hi_n),
    .prf_sel(prf_sel), .prf_we(prf_we), .prf_addr(prf_addr),
    .prf_wdata(prf_wdata), .prf_rdata(prf_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [30:0] w);
    return w[15:0] ^ {w[30:16], 1'b1} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] exp_lane(input logic [31:0] wd, input logic [3:0] m, input logic h);
    logic [15:0] hw = h ? wd[31:16] : wd[15:0];
    logic [1:0]  mh = h ? m[3:2] : m[1:0];
    if (mh == 2'b01) return {hw[7:0], hw[7:0]};
    if (mh == 2'b10) return {hw[15:8], hw[15:8]};
    return hw;
  endfunction

  task automatic idle_check(input string tag);
    check({tag, " R10 strobes"}, {28'd0, le_lo, le_hi, oe_n, we_lo_n}, 32'h3);
    check({tag, " R10 dir/ready"}, {29'd0, we_hi_n, bus_dir, rsp_ready}, 32'h6);
  endtask

  task automatic do_req(input logic we, input logic [31:0] addr, input logic [3:0] mask,
                        input logic [31:0] wd, input logic [1:0] mode);
    logic        peri = &addr[31:8];
    logic        two = &mask;
    int          ntx = two ? 2 : 1;
    logic [31:0] exp_rd = '0;
    logic [31:0] pr;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_mask = mask;
    req_wdata = wd; we_mode = mode;
    @(posedge clk); #2;
    if (peri) begin
      check("R7 prf_sel", {31'd0, prf_sel}, 1);
      check("R7 prf_we", {31'd0, prf_we}, {31'd0, we});
      check("R7 prf_addr", {24'd0, prf_addr}, {24'd0, addr[7:0]});
      if (we) check("R7 prf_wdata", prf_wdata, wd);
      check("R7 no external strobes", {28'd0, le_hi, oe_n, we_lo_n, we_hi_n}, 32'h7);
      pr = $urandom;
      prf_rdata = pr;
      @(posedge clk); #2;
      check("R9 ready after peripheral", {31'd0, rsp_ready}, 1);
      check("R7 prf_sel single cycle", {31'd0, prf_sel}, 0);
      if (!we) check("R7 peripheral read data", rsp_rdata, pr);
    end else begin
      for (int t = 0; t < ntx; t++) begin
        logic        h = two ? t[0] : (mask[1:0] == 2'b00);
        logic [30:0] w = {addr[31:2], h};
        logic [1:0]  mh = h ? mask[3:2] : mask[1:0];
        if (t > 0) begin @(posedge clk); #2; end
        check("R1 le_lo phase", {29'd0, le_lo, le_hi, bus_dir}, 32'h4);
        check(two ? "R4 low address half" : "R5 low address half", {16'd0, ad_out}, {16'd0, w[15:0]});
        @(posedge clk); #2;
        check("R1 le_hi phase", {29'd0, le_lo, le_hi, bus_dir}, 32'h2);
        check("R1 high address half", {16'd0, ad_out}, {17'd0, w[30:16]});
        @(posedge clk); #2;
        check("R2 latches idle in data phase", {30'd0, le_lo, le_hi}, 0);
        if (!we) begin
          check("R2 read phase", {28'd0, oe_n, bus_dir, we_lo_n, we_hi_n}, 32'h7);
          ad_in = pat(w);
          if (h) exp_rd[31:16] = pat(w); else exp_rd[15:0] = pat(w);
        end else begin
          check("R3 write phase", {30'd0, oe_n, bus_dir}, 32'h2);
          check(mh == 2'b11 ? "R4 write data" : "R6 write data", {16'd0, ad_out}, {16'd0, exp_lane(wd, mask, h)});
          check("R8 strobes clk high", {30'd0, we_hi_n, we_lo_n},
                (mode == 2'd1) ? 32'h3 : {30'd0, ~mh});
          #5;
          check("R8 strobes clk low", {30'd0, we_hi_n, we_lo_n},
                (mode == 2'd2) ? 32'h3 : {30'd0, ~mh});
        end
      end
      @(posedge clk); #2;
      ad_in = 16'hDEAD;
      check("R9 ready after data", {31'd0, rsp_ready}, 1);
      if (!we) check(two ? "R4 assembled read" : "R5 half read", rsp_rdata, exp_rd);
    end
    req_valid = 1'b0;
    @(posedge clk); #2;
    check("R9 ready one cycle", {31'd0, rsp_ready}, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] masks [7] = '{4'hF, 4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC};
    logic [31:0] seed = $urandom(32'd20240611);
    seed = '0;
    repeat (3) @(posedge clk);
    #2;
    idle_check("reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    idle_check("idle");

    do_req(1'b0, 32'h1234_5678, 4'hF, 32'h0, 2'd0);
    do_req(1'b1, 32'hFFFF_FEFC, 4'hF, 32'hA1B2_C3D4, 2'd0);
    do_req(1'b1, 32'h0000_0040, 4'h4, 32'h0077_0000, 2'd1);
    do_req(1'b1, 32'h8000_0010, 4'h2, 32'h0000_9900, 2'd2);
    do_req(1'b1, 32'h0000_1000, 4'hC, 32'hBEEF_0000, 2'd3);
    do_req(1'b0, 32'h7FFF_FFFC, 4'h8, 32'h0, 2'd0);
    do_req(1'b0, 32'hFFFF_FF00, 4'hF, 32'h0, 2'd0);
    do_req(1'b1, 32'hFFFF_FFFC, 4'hF, 32'hCAFE_F00D, 2'd0);
    idle_check("after directed");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a = $urandom;
      logic [3:0]  m = masks[$urandom % 7];
      if ($urandom % 6 == 0) a[31:8] = 24'hFFFFFF;
      else if (&a[31:8]) a[31] = 1'b0;
      do_req(1'($urandom), a, m, $urandom, 2'($urandom));
    end
    idle_check("final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule